// File: doc/BRIEF.md
# Two-Channel Halfband 2x Interpolator

This block doubles the sample rate of a stream of 24-bit two's complement audio samples for two channels that share one small arithmetic engine. The engine runs on a system clock far faster than the audio rate. It evaluates one filter tap per clock cycle. Each fixed coefficient is a short sum of signed powers of two, so every product is a handful of shifted adds of the data and no multiplier is needed.

The filter is a symmetric 15-tap halfband. The two taps of each mirrored pair share a coefficient, so the sample pair is added first and the coefficient is applied once. That leaves four accumulate cycles for the interpolated phase. The other output phase is the centre input sample, passed out unchanged. Samples are offered with a channel index. Once both channels hold a fresh sample, the engine shifts the pair into the per-channel delay lines and produces four outputs in a fixed order. It accepts no new input until those four outputs are done.

Top module: `halfband_interp`

## Requirements
- R1: After synchronous reset, `outValid` is low, `inReady` is high, and every delay line and the accumulator hold zero. The first outputs therefore see zero history.
- R2: An input sample is taken only in a cycle where `inValid` and `inReady` are both high. A second sample for the same channel replaces the first one if the pair is not yet complete. `inReady` drops once both channels hold a sample and stays low until the last output of the pair. Samples offered while it is low have no effect on any later output.
- R3: Let the delay line of a channel after the shift be d0 (the newest sample) to d7. The interpolated output is round(S/128), where S = 78(d3+d4) − 18(d2+d5) + 6(d1+d6) − 2(d0+d7).
- R4: The direct-phase output equals d3 exactly, that is, the sample received three pairs before the newest one.
- R5: Each pair yields four outputs in this order: channel 0 interpolated, channel 0 direct, channel 1 interpolated, channel 1 direct. `outChan` gives the channel and `outPhase` is 0 for interpolated and 1 for direct.
- R6: Rounding is to the nearest integer, and an exact half rounds toward plus infinity (S = −64 gives 0, S = +64 gives 1).
- R7: An interpolated result above 8388607 is output as 8388607, and one below −8388608 is output as −8388608.
- R8: Take the clock edge that completes a pair as edge 0. The four outputs are valid after edges 6, 7, 12 and 13, and `inReady` is high again after edge 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input sample offered |
| inChan | input | 1 | Channel of the offered sample |
| inData | input | 24 | Input sample, two's complement |
| inReady | output | 1 | Engine can take a sample |
| outValid | output | 1 | Output sample valid this cycle |
| outChan | output | 1 | Channel of the output sample |
| outPhase | output | 1 | 0 = interpolated, 1 = direct |
| outData | output | 24 | Output sample, two's complement |

## Verification
An impulse on one channel walks through every delay slot, which exposes each coefficient and its sign on its own. The opposite-sign impulse on the other channel shows whether the channels are kept apart. Impulses of ±32 at the outer tap land exactly on rounding ties. Alternating full-scale patterns push the sum past both rails, which exercises saturation. A long pseudo-random sweep and a ramp compare every output against a bench model. Junk samples are offered during each busy period, and a sample is rewritten before its pair completes, which shows whether only the intended samples reach the delay lines.

// File: rtl/halfband_interp_pkg.sv
package halfband_interp_pkg;

  typedef enum logic [1:0] {SPT_NONE, SPT_ADD, SPT_SUB} sptOp_e;

  typedef struct packed {
    sptOp_e     op;
    logic [3:0] shift;
  } sptTerm_t;

  typedef struct packed {
    logic shiftIn;
    logic accFirst;
    logic accEn;
    logic emitComp;
    logic emitDirect;
  } seqStrobe_t;

  localparam int SPT_TERMS = 3;
  localparam int SPT_FRAC  = 7;

  // Coefficient k applies to the pair at distance k from the centre; value = sum of +/- 2^-shift
  function automatic sptTerm_t coefTerm(input int tapIdx, input int termIdx);
    sptTerm_t t;
    t = '{SPT_NONE, 4'd0};
    case (tapIdx)
      0: case (termIdx)
           0: t = '{SPT_ADD, 4'd1};
           1: t = '{SPT_ADD, 4'd3};
           default: t = '{SPT_SUB, 4'd6};
         endcase
      1: case (termIdx)
           0: t = '{SPT_SUB, 4'd3};
           1: t = '{SPT_SUB, 4'd6};
           default: t = '{SPT_NONE, 4'd0};
         endcase
      2: case (termIdx)
           0: t = '{SPT_ADD, 4'd5};
           1: t = '{SPT_ADD, 4'd6};
           default: t = '{SPT_NONE, 4'd0};
         endcase
      default: case (termIdx)
           0: t = '{SPT_SUB, 4'd6};
           default: t = '{SPT_NONE, 4'd0};
         endcase
    endcase
    return t;
  endfunction

endpackage

// File: rtl/halfband_interp_ctrl.sv
module halfband_interp_ctrl
  import halfband_interp_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int NPAIR = 4,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TW   = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [CW-1:0] inChan,
  output logic          inReady,
  output seqStrobe_t    strb,
  output logic [CW-1:0] chan,
  output logic [TW-1:0] tap
);

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_COMP, ST_DIR} seqState_e;

  seqState_e state;
  logic [NCH-1:0] pend;
  logic capture;

  assign inReady = (state == ST_IDLE) && !(&pend);
  assign capture = inValid && inReady && (int'(inChan) < NCH);

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE: strb.shiftIn = &pend;
      ST_ACC: begin
        strb.accEn    = 1'b1;
        strb.accFirst = (tap == '0);
      end
      ST_COMP: strb.emitComp   = 1'b1;
      default: strb.emitDirect = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pend  <= '0;
      chan  <= '0;
      tap   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (&pend) begin
            pend  <= '0;
            chan  <= '0;
            tap   <= '0;
            state <= ST_ACC;
          end else if (capture) begin
            pend[inChan] <= 1'b1;
          end
        end
        ST_ACC: begin
          if (tap == TW'(NPAIR - 1)) state <= ST_COMP;
          else tap <= tap + 1'b1;
        end
        ST_COMP: state <= ST_DIR;
        default: begin
          if (chan == CW'(NCH - 1)) begin
            state <= ST_IDLE;
          end else begin
            chan  <= chan + 1'b1;
            tap   <= '0;
            state <= ST_ACC;
          end
        end
      endcase
    end
  end

  // R8: taps are visited one per cycle in ascending order
  assert_tap_step_R8: assert property (@(posedge clk) disable iff (rst)
    (strb.accEn && tap != '0) |-> ($past(strb.accEn) && $past(tap) == tap - 1'b1));

  // R5: a pair always starts with channel 0, innermost tap
  assert_seq_start_R5: assert property (@(posedge clk) disable iff (rst)
    strb.shiftIn |=> (strb.accEn && tap == '0 && chan == '0));

endmodule

// File: rtl/halfband_interp_dpath.sv
module halfband_interp_dpath
  import halfband_interp_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int GUARD_W = 4,
  parameter int NCH     = 2,
  parameter int NPAIR   = 4,
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TW     = (NPAIR > 1) ? $clog2(NPAIR) : 1,
  localparam int DLEN   = 2 * NPAIR,
  localparam int DW     = $clog2(DLEN),
  localparam int ACC_W  = DATA_W + GUARD_W + SPT_FRAC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     capture,
  input  logic [CW-1:0]            inChan,
  input  logic signed [DATA_W-1:0] inData,
  input  seqStrobe_t               strb,
  input  logic [CW-1:0]            chan,
  input  logic [TW-1:0]            tap,
  output logic                     outValid,
  output logic [CW-1:0]            outChan,
  output logic                     outPhase,
  output logic signed [DATA_W-1:0] outData
);

  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (SPT_FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;

  logic signed [DATA_W-1:0] hold [NCH];
  logic signed [DATA_W-1:0] dl   [NCH][DLEN];
  logic signed [ACC_W-1:0]  acc, prod, pairExt, shr;
  logic signed [DATA_W-1:0] satVal;
  logic [DW-1:0] idxLo, idxHi;

  assign idxLo = DW'(NPAIR - 1) - DW'(tap);
  assign idxHi = DW'(NPAIR) + DW'(tap);
  assign pairExt = ACC_W'(dl[chan][idxLo]) + ACC_W'(dl[chan][idxHi]);

  // Shift-add product: one pre-added pair times one signed-power-of-two coefficient
  always_comb begin
    prod = '0;
    for (int g = 0; g < SPT_TERMS; g++) begin
      sptTerm_t term;
      logic signed [ACC_W-1:0] shifted;
      term    = coefTerm(int'(tap), g);
      shifted = pairExt <<< (SPT_FRAC - int'(term.shift));
      case (term.op)
        SPT_ADD: prod = prod + shifted;
        SPT_SUB: prod = prod - shifted;
        default: ;
      endcase
    end
  end

  assign shr = (acc + HALF_LSB) >>> SPT_FRAC;

  always_comb begin
    if (shr > MAXV)      satVal = MAXV[DATA_W-1:0];
    else if (shr < MINV) satVal = MINV[DATA_W-1:0];
    else                 satVal = shr[DATA_W-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        hold[c] <= '0;
        for (int k = 0; k < DLEN; k++) dl[c][k] <= '0;
      end else begin
        if (capture && inChan == CW'(c)) hold[c] <= inData;
        if (strb.shiftIn) begin
          dl[c][0] <= hold[c];
          for (int k = 1; k < DLEN; k++) dl[c][k] <= dl[c][k-1];
        end
      end
    end

    // R2: delay lines only move when a completed pair is shifted in
    assert_line_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !strb.shiftIn |=> (dl[c][0] == $past(dl[c][0])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      outValid <= 1'b0;
      outChan  <= '0;
      outPhase <= 1'b0;
      outData  <= '0;
    end else begin
      if (strb.accEn) acc <= strb.accFirst ? prod : acc + prod;
      outValid <= strb.emitComp | strb.emitDirect;
      if (strb.emitComp | strb.emitDirect) begin
        outChan  <= chan;
        outPhase <= strb.emitDirect;
        outData  <= strb.emitComp ? satVal : dl[chan][NPAIR-1];
      end
    end
  end

  // R5: an interpolated emit strobe shows up as a phase-0 output next cycle
  assert_comp_tag_R5: assert property (@(posedge clk) disable iff (rst)
    strb.emitComp |=> (outValid && !outPhase));

endmodule

// File: rtl/halfband_interp.sv
module halfband_interp
  import halfband_interp_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int GUARD_W = 4,
  parameter int NCH     = 2,
  parameter int NPAIR   = 4,
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TW     = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic [CW-1:0]            inChan,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     inReady,
  output logic                     outValid,
  output logic [CW-1:0]            outChan,
  output logic                     outPhase,
  output logic signed [DATA_W-1:0] outData
);

  seqStrobe_t    strb;
  logic [CW-1:0] chan;
  logic [TW-1:0] tap;

  halfband_interp_ctrl #(.NCH(NCH), .NPAIR(NPAIR)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inChan(inChan),
    .inReady(inReady), .strb(strb), .chan(chan), .tap(tap)
  );

  halfband_interp_dpath #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .NCH(NCH), .NPAIR(NPAIR)) u_dpath (
    .clk(clk), .rst(rst), .capture(inValid && inReady), .inChan(inChan), .inData(inData),
    .strb(strb), .chan(chan), .tap(tap),
    .outValid(outValid), .outChan(outChan), .outPhase(outPhase), .outData(outData)
  );

  // R5: every interpolated output is followed at once by the direct output of the same channel
  assert_pair_order_R5: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outPhase) |=> (outValid && outPhase && outChan == $past(outChan)));

endmodule

// File: tb/sim_halfband_interp.sv
module sim_halfband_interp;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inChan = 1'b0;
  logic signed [23:0] inData = '0;
  logic inReady, outValid, outChan, outPhase;
  logic signed [23:0] outData;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  longint hist [2][8];
  int seed = 32'h1234abcd;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  halfband_interp u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inChan(inChan), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outChan(outChan),
    .outPhase(outPhase), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return seed;
  endfunction

  // Model of R3/R6/R7: returns result and the requirement it mainly exercises
  function automatic longint modelComp(input int c, output string tag);
    longint s, r;
    s = 78 * (hist[c][3] + hist[c][4]) - 18 * (hist[c][2] + hist[c][5])
      + 6 * (hist[c][1] + hist[c][6]) - 2 * (hist[c][0] + hist[c][7]);
    r = (s + 64) >>> 7;
    tag = ((s % 128) == 64 || (s % 128) == -64) ? "R6" : "R3";
    if (r > 8388607) begin r = 8388607; tag = "R7"; end
    if (r < -8388608) begin r = -8388608; tag = "R7"; end
    return r;
  endfunction

  task automatic sendPair(input logic signed [23:0] a, input logic signed [23:0] b, input bit dup);
    int c0;
    longint expData [4];
    string expTag [4];
    int seen;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    if (dup) begin
      inValid = 1'b1; inChan = 1'b0; inData = ~a;
      @(negedge clk);
    end
    inValid = 1'b1; inChan = 1'b0; inData = a;
    @(negedge clk);
    inChan = 1'b1; inData = b;
    @(negedge clk);
    c0 = cyc;
    for (int c = 0; c < 2; c++)
      for (int k = 7; k > 0; k--) hist[c][k] = hist[c][k-1];
    hist[0][0] = longint'(a);
    hist[1][0] = longint'(b);
    expData[0] = modelComp(0, expTag[0]);
    expData[1] = hist[0][3]; expTag[1] = "R4";
    expData[2] = modelComp(1, expTag[2]);
    expData[3] = hist[1][3]; expTag[3] = "R4";
    if (dup) expTag[0] = "R2";
    seen = 0;
    for (int rel = 0; rel <= 14; rel++) begin
      int slot;
      if (rel > 0) @(negedge clk);
      slot = (rel == 6) ? 0 : (rel == 7) ? 1 : (rel == 12) ? 2 : (rel == 13) ? 3 : -1;
      if (rel == 0 || rel == 12 || rel == 13)
        check(inReady == (rel >= 13), "R8 inReady", longint'(inReady), longint'(rel >= 13));
      if (slot >= 0) begin
        check(outValid == 1'b1, "R8 outValid", longint'(outValid), 1);
        check(outChan == slot[1] && outPhase == slot[0], "R5 order",
              longint'({outChan, outPhase}), longint'(slot));
        check(longint'(outData) == expData[slot], expTag[slot], longint'(outData), expData[slot]);
        seen++;
      end else if (outValid) begin
        check(1'b0, "R8 stray outValid", 1, 0);
      end
      // junk offered while busy must be ignored (R2)
      if (rel <= 11) begin
        inValid = 1'b1; inChan = rel[0]; inData = 24'(nextRand());
      end else begin
        inValid = 1'b0;
      end
    end
    if (seen != 4) check(1'b0, "R5 output count", seen, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int k = 0; k < 8; k++) hist[c][k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", longint'(outValid), 0);
    check(inReady == 1'b1, "R1 inReady after reset", longint'(inReady), 1);

    // R1: first pair sees cleared history; impulse walks every delay slot (R3, R4)
    sendPair(24'sd65536, -24'sd32768, 1'b0);
    for (int i = 0; i < 8; i++) sendPair(24'sd0, 24'sd0, 1'b0);

    // R6: ties at the outer tap, both signs
    sendPair(24'sd32, -24'sd32, 1'b0);
    for (int i = 0; i < 8; i++) sendPair(24'sd0, 24'sd0, 1'b0);

    // R7: patterns aligned with coefficient signs, positive on ch0, negative on ch1
    begin
      logic signed [23:0] mx, mn;
      mx = 24'sh7fffff; mn = 24'sh800000;
      sendPair(mn, mx, 1'b0);
      sendPair(mx, mn, 1'b0);
      sendPair(mn, mx, 1'b0);
      sendPair(mx, mn, 1'b0);
      sendPair(mx, mn, 1'b0);
      sendPair(mn, mx, 1'b0);
      sendPair(mx, mn, 1'b0);
      sendPair(mn, mx, 1'b0);
    end

    // R2: sample rewritten before its pair completes
    sendPair(24'sd123456, -24'sd654321, 1'b1);

    // ramp
    for (int i = 0; i < 12; i++) sendPair(24'(i * 700000 - 4000000), 24'(3000000 - i * 500000), 1'b0);

    // pseudo-random sweep
    for (int i = 0; i < 60; i++) sendPair(24'(nextRand() >>> 5), 24'(nextRand() >>> 5), (i % 7) == 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule